// File: doc/BRIEF.md
# Far-End Alarm Code Word Receiver

This block watches the serial far-end alarm and control bit stream that a DS3 framer pulls out of the C-bits when it runs in C-bit parity mode. Each incoming bit arrives with a qualifier. The block searches for a legal 16-bit code word at any bit alignment. Once it has locked onto a word, it expects the next one exactly 16 bits later, and it counts how many times in a row the same word repeats.

A code word is validated either on its first reception or on its tenth consecutive one, depending on a mode input. A validated code lands in a one-byte receive stack that the host reads. The block also notices when the channel falls idle after a code word.

Three interrupt sources can raise a single interrupt line, and each has its own enable:
- a code word was validated;
- the stack holds unread data;
- idle has started.

Top module: `feac_rx`

## Requirements
- R1: While `cbit_mode` is 0, incoming bits are ignored and any partial search or repeat count is discarded. No code is validated, and the code interrupt source is masked.
- R2: A legal word is the 16 bits `0 d5 d4 d3 d2 d1 d0 0 1 1 1 1 1 1 1 1`, oldest bit first. It is recognised at any alignment, once at least 16 bits have been received since mode entry or since the last accepted word. `stack_code[5]` is d5 and `stack_code[0]` is d0.
- R3: With `cfg_single`=1, every accepted word is validated. It is written to `stack_code`, and `stack_valid` and `code_pend` are set one clock after the last bit.
- R4: With `cfg_single`=0, a word is validated only when the same code has arrived 10 times back to back, 16 bits apart. Further repeats of that code do not validate it again.
- R5: A missing word at the expected 16-bit point restarts the repeat count at zero. An accepted word with a different code restarts the count at one.
- R6: `irq` includes `ie_code & code_pend & cbit_mode`. With all three enables at 0, `irq` is 0.
- R7: `irq` includes `ie_stack & stack_valid`, whatever the setting of `cfg_single`.
- R8: If 16 consecutive 1 bits follow an accepted word, `idle_pend` is set once, and a continuing run of ones does not set it again. `clr_idle` clears `idle_pend`. `irq` includes `ie_idle & idle_pend`.
- R9: A `rd_stack` pulse clears `stack_valid`, `stack_ovr` and `code_pend`. A validation in the same cycle wins and leaves `stack_ovr` at 0.
- R10: A validation while `stack_valid` is 1 and no read is given overwrites `stack_code` and sets `stack_ovr`.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cbit_mode | input | 1 | 1 when the line runs in C-bit parity mode |
| cfg_single | input | 1 | 1 selects single validation, 0 selects ten-repeat validation |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Received channel bit |
| ie_code | input | 1 | Enable for the code-validated interrupt source |
| ie_stack | input | 1 | Enable for the stack-not-empty interrupt source |
| ie_idle | input | 1 | Enable for the idle-start interrupt source |
| rd_stack | input | 1 | Host read strobe for the stack byte |
| clr_idle | input | 1 | Host clear for the idle flag |
| stack_code | output | 6 | Last validated code |
| stack_valid | output | 1 | Stack holds unread data |
| stack_ovr | output | 1 | A validation overwrote unread data |
| code_pend | output | 1 | Code-validated event pending |
| idle_pend | output | 1 | Idle-start event pending |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is a ten-word repeat run that is broken near its end, either by a different code or by one missing word. From the ports, the only sign of such a break is that no validation happens where one otherwise would. Directed sequences send nine words and then break the run, or send five of one code and then ten of another. Random segments draw their codes from a pool of three values and their repeat lengths from a range that straddles ten, so broken runs and overlapping runs keep occurring under both validation modes. These segments also interleave idle runs, noise bits, host reads and mode drops.

// File: rtl/feac_rx.sv
module feac_rx #(
  parameter int REPS     = 10,
  parameter int IDLE_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cbit_mode,
  input  logic       cfg_single,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       ie_code,
  input  logic       ie_stack,
  input  logic       ie_idle,
  input  logic       rd_stack,
  input  logic       clr_idle,
  output logic [5:0] stack_code,
  output logic       stack_valid,
  output logic       stack_ovr,
  output logic       code_pend,
  output logic       idle_pend,
  output logic       irq
);
  localparam int WLEN = 16;
  localparam int FW   = $clog2(WLEN + 1);
  localparam int RW   = $clog2(REPS + 1);
  localparam int IW   = $clog2(IDLE_LEN + 1);

  logic [WLEN-1:0] sr;
  logic [FW-1:0]   fill;
  logic [RW-1:0]   rep;
  logic [IW-1:0]   ones;
  logic            seen;
  logic [5:0]      last;

  wire [WLEN-1:0] sr_nx   = {sr[WLEN-2:0], bit_in};
  wire [5:0]      code_nx = sr_nx[14:9];
  wire            en      = cbit_mode & bit_vld;
  wire            legal   = !sr_nx[15] && !sr_nx[8] && (&sr_nx[7:0]);
  wire            at_edge = (fill == FW'(WLEN - 1));
  wire            chk     = at_edge || (rep == '0 && fill == FW'(WLEN));
  wire            hit     = en && chk && legal;
  wire            same    = (rep != '0) && (code_nx == last);
  wire [RW-1:0]   rep_nx  = !same ? RW'(1) : (rep == RW'(REPS)) ? rep : rep + RW'(1);
  wire            done    = hit && (cfg_single || (same && rep == RW'(REPS - 1)));
  wire            idle_hit = en && !hit && bit_in && seen && (ones == IW'(IDLE_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0; fill <= '0; rep <= '0; ones <= '0; seen <= 1'b0; last <= '0;
      stack_code <= '0; stack_valid <= 1'b0; stack_ovr <= 1'b0;
      code_pend <= 1'b0; idle_pend <= 1'b0;
    end else begin
      if (!cbit_mode) begin
        fill <= '0; rep <= '0; ones <= '0; seen <= 1'b0;
      end else if (bit_vld) begin
        sr <= sr_nx;
        if (hit) begin
          rep <= rep_nx; last <= code_nx; fill <= '0; ones <= '0; seen <= 1'b1;
        end else begin
          if (at_edge && rep != '0) rep <= '0;
          if (fill != FW'(WLEN)) fill <= fill + FW'(1);
          if (!bit_in) ones <= '0;
          else if (ones != IW'(IDLE_LEN)) ones <= ones + IW'(1);
          if (idle_hit) seen <= 1'b0;
        end
      end

      if (done) begin
        stack_code  <= code_nx;
        stack_ovr   <= stack_valid && !rd_stack;
        stack_valid <= 1'b1;
        code_pend   <= 1'b1;
      end else if (rd_stack) begin
        stack_valid <= 1'b0;
        stack_ovr   <= 1'b0;
        code_pend   <= 1'b0;
      end

      if (idle_hit) idle_pend <= 1'b1;
      else if (clr_idle) idle_pend <= 1'b0;
    end
  end

  assign irq = (ie_code & code_pend & cbit_mode) | (ie_stack & stack_valid) | (ie_idle & idle_pend);
endmodule

module feac_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic cbit_mode,
  input logic ie_code,
  input logic ie_stack,
  input logic ie_idle,
  input logic rd_stack,
  input logic stack_valid,
  input logic stack_ovr,
  input logic code_pend,
  input logic idle_pend,
  input logic irq
);
  AST_OFF_NO_VALID:  assert property (@(posedge clk) disable iff (!rst_n) !cbit_mode && !stack_valid |=> !stack_valid); // R1
  AST_OVR_VALID:     assert property (@(posedge clk) disable iff (!rst_n) stack_ovr |-> stack_valid); // R10
  AST_PEND_VALID:    assert property (@(posedge clk) disable iff (!rst_n) code_pend |-> stack_valid); // R3
  AST_CODE_IRQ:      assert property (@(posedge clk) disable iff (!rst_n) ie_code && code_pend && cbit_mode |-> irq); // R6
  AST_QUIET:         assert property (@(posedge clk) disable iff (!rst_n) !ie_code && !ie_stack && !ie_idle |-> !irq); // R6
  AST_STACK_IRQ:     assert property (@(posedge clk) disable iff (!rst_n) ie_stack && stack_valid |-> irq); // R7
  AST_IDLE_IRQ:      assert property (@(posedge clk) disable iff (!rst_n) ie_idle && idle_pend |-> irq); // R8
  AST_READ_CLEARS:   assert property (@(posedge clk) disable iff (!rst_n) rd_stack && !cbit_mode |=> !stack_valid && !stack_ovr && !code_pend); // R9
endmodule

bind feac_rx feac_rx_chk i_chk (.*);

// File: tb/test_feac_rx.sv
`timescale 1ns/1ps
module test_feac_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cbit_mode = 1'b0, cfg_single = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic ie_code = 1'b0, ie_stack = 1'b0, ie_idle = 1'b0, rd_stack = 1'b0, clr_idle = 1'b0;
  logic [5:0] stack_code;
  logic stack_valid, stack_ovr, code_pend, idle_pend, irq;

  always #4 clk = ~clk;

  feac_rx i_feac_rx (.*);

  int n_vec = 0, n_bad = 0;
  logic [15:0] mh;
  int mfill, mrep, mones;
  bit mseen, msv, movr, mcp, mip;
  logic [5:0] mlast, mcode;

  task automatic chk(string what, string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_irq();
    return (ie_code & mcp & cbit_mode) | (ie_stack & msv) | (ie_idle & mip);
  endfunction

  task automatic m_reset();
    mh = '0; mfill = 0; mrep = 0; mones = 0; mseen = 0; mlast = '0;
    mcode = '0; msv = 0; movr = 0; mcp = 0; mip = 0;
  endtask

  task automatic m_update(bit v, bit b, bit rd, bit clr);
    bit done = 0, idl = 0, legal, hit;
    logic [5:0] c;
    if (!cbit_mode) begin
      mfill = 0; mrep = 0; mones = 0; mseen = 0;
    end else if (v) begin
      mh = {mh[14:0], b};
      legal = (mh[15] == 0) && (mh[8] == 0) && (mh[7:0] == 8'hFF);
      hit = legal && ((mfill == 15) || (mrep == 0 && mfill >= 16));
      c = mh[14:9];
      if (hit) begin
        if (mrep != 0 && c == mlast) begin
          if (mrep == 9) done = 1;
          if (mrep < 10) mrep++;
        end else mrep = 1;
        if (cfg_single) done = 1;
        mlast = c; mfill = 0; mones = 0; mseen = 1;
      end else begin
        if (mfill == 15 && mrep != 0) mrep = 0;
        if (mfill < 16) mfill++;
        if (!b) mones = 0;
        else begin
          if (mones < 16) mones++;
          if (mones == 16 && mseen) begin idl = 1; mseen = 0; end
        end
      end
    end
    if (done) begin
      movr = msv && !rd; msv = 1; mcp = 1; mcode = mh[14:9];
    end else if (rd) begin
      msv = 0; movr = 0; mcp = 0;
    end
    if (idl) mip = 1; else if (clr) mip = 0;
  endtask

  task automatic step(bit v, bit b, bit rd, bit clr);
    @(negedge clk);
    bit_vld = v; bit_in = b; rd_stack = rd; clr_idle = clr;
    @(posedge clk); #1;
    m_update(v, b, rd, clr);
    chk("stack_code", "R2", stack_code, mcode);
    chk("stack_valid", "R3", stack_valid, msv);
    chk("stack_ovr", "R10", stack_ovr, movr);
    chk("code_pend", "R9", code_pend, mcp);
    chk("idle_pend", "R8", idle_pend, mip);
    chk("irq", "R6", irq, m_irq());
  endtask

  task automatic send_word(logic [5:0] d);
    logic [15:0] w = {1'b0, d, 1'b0, 8'hFF};
    for (int i = 15; i >= 0; i--) step(1, w[i], 0, 0);
  endtask

  task automatic send_ones(int n);
    for (int i = 0; i < n; i++) step(1, 1, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; bit_vld = 0; rd_stack = 0; clr_idle = 0;
    @(posedge clk); @(negedge clk); rst_n = 1;
    m_reset();
  endtask

  task automatic read_stack();
    step(0, 0, 1, 0);
  endtask

  initial begin
    #1_600_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    #1;
    chk("reset stack_valid R11", "R11", stack_valid, 0);
    chk("reset code R11", "R11", stack_code, 0);
    chk("reset pends R11", "R11", {stack_ovr, code_pend, idle_pend, irq}, 0);

    // R1: mode off, words ignored
    cfg_single = 1; ie_stack = 1;
    send_word(6'h15); send_word(6'h15);
    chk("mode off valid R1", "R1", stack_valid, 0);

    // R2/R3: single mode, offset alignment
    cbit_mode = 1;
    step(1, 1, 0, 0); step(1, 0, 0, 0); step(1, 1, 0, 0);
    send_word(6'h2A);
    chk("single code R2", "R2", stack_code, 6'h2A);
    chk("single valid R3", "R3", stack_valid, 1);
    chk("stack irq R7", "R7", irq, 1);
    ie_stack = 0; ie_code = 1; #1;
    chk("code irq R6", "R6", irq, 1);
    cbit_mode = 0; #1;
    chk("code irq masked off mode R1", "R1", irq, 0);
    cbit_mode = 1;
    read_stack();
    chk("read clears R9", "R9", {stack_valid, code_pend}, 0);

    // R10: overrun
    send_word(6'h01); send_word(6'h3E);
    chk("overrun flag R10", "R10", stack_ovr, 1);
    chk("overrun code R10", "R10", stack_code, 6'h3E);
    read_stack();

    // R8: idle start once
    ie_code = 0; ie_idle = 1;
    send_ones(16);
    chk("idle set R8", "R8", idle_pend, 1);
    chk("idle irq R8", "R8", irq, 1);
    step(1, 1, 0, 1);
    send_ones(20);
    chk("idle not retriggered R8", "R8", idle_pend, 0);
    ie_idle = 0;

    // R4: ten repeats
    do_reset(); cbit_mode = 1; cfg_single = 0;
    for (int i = 0; i < 9; i++) send_word(6'h11);
    chk("nine repeats R4", "R4", stack_valid, 0);
    send_word(6'h11);
    chk("tenth repeat R4", "R4", stack_valid, 1);
    read_stack();
    send_word(6'h11); send_word(6'h11);
    chk("no revalidate R4", "R4", stack_valid, 0);

    // R5: code change and missing word restart
    do_reset(); cbit_mode = 1; cfg_single = 0;
    for (int i = 0; i < 5; i++) send_word(6'h11);
    for (int i = 0; i < 9; i++) send_word(6'h22);
    chk("changed code restarts R5", "R5", stack_valid, 0);
    send_word(6'h22);
    chk("changed code tenth R5", "R5", stack_code, 6'h22);
    read_stack();
    do_reset(); cbit_mode = 1; cfg_single = 0;
    for (int i = 0; i < 9; i++) send_word(6'h07);
    send_ones(16);
    send_word(6'h07);
    chk("gap restarts R5", "R5", stack_valid, 0);

    // random segments
    for (int s = 0; s < 400; s++) begin
      int k = $urandom_range(0, 9);
      ie_code = $urandom_range(0, 1); ie_stack = $urandom_range(0, 1); ie_idle = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) cfg_single = ~cfg_single;
      if ($urandom_range(0, 15) == 0) cbit_mode = ~cbit_mode;
      if (k < 5) begin
        logic [5:0] d = (k == 0) ? 6'h11 : (k == 1) ? 6'h3F : 6'h0C;
        int n = $urandom_range(1, 12);
        for (int i = 0; i < n; i++) send_word(d);
      end else if (k < 7) send_ones($urandom_range(10, 20));
      else if (k == 7) begin
        for (int i = 0; i < 8; i++) step($urandom_range(0, 1), $urandom_range(0, 1), 0, 0);
      end else step(0, 0, $urandom_range(0, 1), $urandom_range(0, 1));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule